// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block handles exception entry and return for a small 32-bit soft processor. The pipeline raises a one-cycle request with a 3-bit cause code and the program counter of the faulting instruction. One clock later the block emits a redirect: the handler address, which is a base register plus the cause times 32. In the same cycle it emits a write strobe that tells the register file which link register receives the saved program counter. The block also updates its interrupt-enable state. Normal and debug exceptions each have their own return register and their own saved-enable bit.

Two base registers and a remap control bit are reachable through a small register port. The two bases are the normal base and the debug base. When the remap bit is set, normal exceptions vector through the debug base. Two return commands restore the global enable from the matching saved bit and redirect to the matching return address. One is return-from-exception and the other is return-from-breakpoint.

Top module: `exc_entry_ctl`

## Requirements
- R1: Cause codes are as follows. Values 0 to 4 are normal causes: instruction bus error, data bus error, divide-by-zero, external interrupt and system call. Values 5 and 6 are debug causes: breakpoint and watchpoint. Value 7 is undefined.
- R2: A request with a defined cause produces, on the next cycle, `redirect_valid`=1 and `redirect_pc` = selected base + cause*32.
- R3: A normal-cause request asserts `link_we` with `link_sel`=0 and `link_data`=`exc_pc` on the next cycle. The block keeps that value as the exception return address.
- R4: A debug-cause request asserts `link_we` with `link_sel`=1 and `link_data`=`exc_pc`. The block keeps that value as the breakpoint return address.
- R5: A normal entry ORs the global enable into the exception-saved bit and then clears the global enable. If the global enable was 0, the saved bit is left unchanged.
- R6: A debug entry ORs the global enable into the breakpoint-saved bit and then clears the global enable. The exception-saved bit is untouched.
- R7: Normal causes use the normal base when remap is 0 and the debug base when remap is 1. Debug causes always use the debug base.
- R8: `ret_exc` copies the exception-saved bit into the global enable. On the next cycle it gives `redirect_valid`=1, `redirect_pc` = the exception return address, and `link_we`=0.
- R9: `ret_dbg` does the same using the breakpoint-saved bit and the breakpoint return address.
- R10: The register port selects registers with `cfg_sel` as follows:
  - 0 is the normal base.
  - 1 is the debug base.
  - 2 is the control register, with remap at bit 0.
  - 3 is the enable register, with the global enable at bit 0, the exception-saved bit at bit 1 and the breakpoint-saved bit at bit 2.
  
  Reads on `cfg_rdata` are combinational. Bits 7:0 of both bases always read 0. After reset every register reads 0.
- R11: A request with cause 7 pulses `cause_err` on the next cycle. It causes no redirect, no link write and no state change.
- R12: While `exc_req` is high, both return commands and any enable-register write are ignored. `ret_exc` wins over `ret_dbg`, and a return wins over an enable-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_cause | input | 3 | Cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| ret_exc | input | 1 | Return-from-exception command |
| ret_dbg | input | 1 | Return-from-breakpoint command |
| cfg_we | input | 1 | Register port write enable |
| cfg_sel | input | 2 | Register port select |
| cfg_wdata | input | 32 | Register port write data |
| cfg_rdata | output | 32 | Register port read data |
| redirect_valid | output | 1 | Redirect PC is valid this cycle |
| redirect_pc | output | 32 | Next program counter |
| link_we | output | 1 | Link register write strobe |
| link_sel | output | 1 | 0 = exception return register, 1 = breakpoint return register |
| link_data | output | 32 | Value written to the link register |
| cause_err | output | 1 | Undefined cause seen |

## Verification
The assertions check the following on every cycle:
- the global enable is clear after any entry;
- a saved bit stays unchanged when it is entered with the enable low;
- entry redirects land on 32-byte slots;
- a link strobe always comes with a redirect;
- an undefined cause leaves the enable state alone.

Several behaviours can only be shown by the bench's scenarios. These are the base selection under remap, the return paths that restore a saved bit after it was set, and the precedence rules between simultaneous requests, returns and writes. The bench compares them against its own reference model.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN       = 32;
    localparam int CAUSE_W    = 3;
    localparam int SLOT_SHIFT = 5;
    localparam int BASE_LSB   = 8;
    localparam int SEL_W      = 2;

    typedef enum logic [CAUSE_W-1:0] {
        C_IBUS  = 3'd0,
        C_DBUS  = 3'd1,
        C_DIVZ  = 3'd2,
        C_IRQ   = 3'd3,
        C_SCALL = 3'd4,
        C_BRK   = 3'd5,
        C_WATCH = 3'd6,
        C_RSVD  = 3'd7
    } cause_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_NBASE = 2'd0,
        SEL_DBASE = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_EN    = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic bie;
        logic eie;
        logic ie;
    } en_t;

    typedef struct packed {
        logic take_norm;
        logic take_dbg;
        logic do_rete;
        logic do_retb;
        logic bad;
    } action_t;

    function automatic logic cause_defined(input cause_e c);
        return c != C_RSVD;
    endfunction

    function automatic logic cause_debug(input cause_e c);
        return (c == C_BRK) || (c == C_WATCH);
    endfunction

endpackage

// File: rtl/exc_base_regs.sv
module exc_base_regs
    import exc_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int LSB = BASE_LSB
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  cfg_sel_e     cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    output logic [W-1:0] nbase,
    output logic [W-1:0] dbase,
    output logic         remap
);
    localparam int HI_W = W - LSB;

    logic [1:0][HI_W-1:0] base_hi;

    for (genvar g = 0; g < 2; g++) begin : g_base
        localparam cfg_sel_e MY_SEL = (g == 0) ? SEL_NBASE : SEL_DBASE;
        always_ff @(posedge clk) begin
            if (rst)
                base_hi[g] <= '0;
            else if (cfg_we && cfg_sel == MY_SEL)
                base_hi[g] <= cfg_wdata[W-1:LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            remap <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_CTRL)
            remap <= cfg_wdata[0];
    end

    assign nbase = {base_hi[0], {LSB{1'b0}}};
    assign dbase = {base_hi[1], {LSB{1'b0}}};

    // R10: a base write lands with its low byte dropped
    a_r10_nbase_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_NBASE) |=> nbase[W-1:LSB] == $past(cfg_wdata[W-1:LSB]));

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int SHIFT = SLOT_SHIFT
) (
    input  logic         use_debug_base,
    input  logic [W-1:0] nbase,
    input  logic [W-1:0] dbase,
    input  cause_e       cause,
    output logic [W-1:0] vector
);
    logic [W-1:0] base_sel;
    logic [W-1:0] offset;

    always_comb begin
        base_sel = use_debug_base ? dbase : nbase;
        offset   = W'(cause) << SHIFT;
        vector   = base_sel + offset;
    end

endmodule

// File: rtl/exc_enable_ctl.sv
module exc_enable_ctl
    import exc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  action_t act,
    input  logic    wr_en,
    input  en_t     wr_val,
    output en_t     en_q
);
    en_t en_d;

    always_comb begin
        en_d = en_q;
        if (act.take_norm) begin
            en_d.eie = en_q.eie | en_q.ie;
            en_d.ie  = 1'b0;
        end else if (act.take_dbg) begin
            en_d.bie = en_q.bie | en_q.ie;
            en_d.ie  = 1'b0;
        end else if (act.do_rete) begin
            en_d.ie  = en_q.eie;
        end else if (act.do_retb) begin
            en_d.ie  = en_q.bie;
        end else if (wr_en) begin
            en_d = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    // R5/R6: any entry leaves the global enable cleared
    a_r5_ie_cleared: assert property (@(posedge clk) disable iff (rst)
        (act.take_norm || act.take_dbg) |=> !en_q.ie);
    // R5: entering with enable low keeps the saved bit
    a_r5_eie_kept: assert property (@(posedge clk) disable iff (rst)
        (act.take_norm && !en_q.ie) |=> en_q.eie == $past(en_q.eie));
    // R6: debug entry leaves the exception-saved bit alone
    a_r6_eie_untouched: assert property (@(posedge clk) disable iff (rst)
        act.take_dbg |=> en_q.eie == $past(en_q.eie));
    // R8: return restores from the exception-saved bit
    a_r8_restore: assert property (@(posedge clk) disable iff (rst)
        act.do_rete |=> en_q.ie == $past(en_q.eie));
    // R11: an undefined cause changes nothing
    a_r11_bad_quiet: assert property (@(posedge clk) disable iff (rst)
        act.bad |=> en_q == $past(en_q));

endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
    import exc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                exc_req,
    input  logic [CAUSE_W-1:0]  exc_cause,
    input  logic [XLEN-1:0]     exc_pc,
    input  logic                ret_exc,
    input  logic                ret_dbg,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [XLEN-1:0]     cfg_wdata,
    output logic [XLEN-1:0]     cfg_rdata,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc,
    output logic                link_we,
    output logic                link_sel,
    output logic [XLEN-1:0]     link_data,
    output logic                cause_err
);
    cause_e          cause;
    cfg_sel_e        sel;
    action_t         act;
    en_t             en_q;
    en_t             en_wr;
    logic            en_wr_en;
    logic [XLEN-1:0] nbase, dbase, vector;
    logic            remap;
    logic [XLEN-1:0] ea_q, ba_q;

    assign cause = cause_e'(exc_cause);
    assign sel   = cfg_sel_e'(cfg_sel);

    always_comb begin
        act           = '0;
        act.take_norm = exc_req && cause_defined(cause) && !cause_debug(cause);
        act.take_dbg  = exc_req && cause_debug(cause);
        act.bad       = exc_req && !cause_defined(cause);
        act.do_rete   = !exc_req && ret_exc;
        act.do_retb   = !exc_req && !ret_exc && ret_dbg;
    end

    assign en_wr_en = cfg_we && sel == SEL_EN && !exc_req && !ret_exc && !ret_dbg;
    assign en_wr    = en_t'(cfg_wdata[2:0]);

    exc_base_regs u_base (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (sel),
        .cfg_wdata (cfg_wdata),
        .nbase     (nbase),
        .dbase     (dbase),
        .remap     (remap)
    );

    exc_vector_calc u_vec (
        .use_debug_base (act.take_dbg || remap),
        .nbase          (nbase),
        .dbase          (dbase),
        .cause          (cause),
        .vector         (vector)
    );

    exc_enable_ctl u_en (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .wr_en  (en_wr_en),
        .wr_val (en_wr),
        .en_q   (en_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q <= '0;
            ba_q <= '0;
        end else begin
            if (act.take_norm) ea_q <= exc_pc;
            if (act.take_dbg)  ba_q <= exc_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            link_we        <= 1'b0;
            link_sel       <= 1'b0;
            link_data      <= '0;
            cause_err      <= 1'b0;
        end else begin
            redirect_valid <= act.take_norm || act.take_dbg || act.do_rete || act.do_retb;
            link_we        <= act.take_norm || act.take_dbg;
            link_sel       <= act.take_dbg;
            link_data      <= (act.take_norm || act.take_dbg) ? exc_pc : '0;
            cause_err      <= act.bad;
            if (act.take_norm || act.take_dbg) redirect_pc <= vector;
            else if (act.do_rete)              redirect_pc <= ea_q;
            else if (act.do_retb)              redirect_pc <= ba_q;
            else                               redirect_pc <= '0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_NBASE: cfg_rdata = nbase;
            SEL_DBASE: cfg_rdata = dbase;
            SEL_CTRL:  cfg_rdata = {{(XLEN-1){1'b0}}, remap};
            default:   cfg_rdata = {{(XLEN-3){1'b0}}, en_q};
        endcase
    end

    // R2/R3: entry redirects land on a 32-byte slot
    a_r2_slot_aligned: assert property (@(posedge clk) disable iff (rst)
        link_we |-> redirect_pc[SLOT_SHIFT-1:0] == '0);
    // R3/R4: a link strobe always accompanies a redirect
    a_r3_link_with_redirect: assert property (@(posedge clk) disable iff (rst)
        link_we |-> redirect_valid);
    // R11: error pulse carries no redirect or link write
    a_r11_err_silent: assert property (@(posedge clk) disable iff (rst)
        cause_err |-> (!redirect_valid && !link_we));
    // R4: debug entry records the faulting PC in the breakpoint register
    a_r4_ba_capture: assert property (@(posedge clk) disable iff (rst)
        (link_we && link_sel) |-> ba_q == link_data);

endmodule

// File: tb/sim_exc_entry_ctl.sv
module sim_exc_entry_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [2:0]  exc_cause = '0;
    logic [31:0] exc_pc = '0;
    logic        ret_exc = 1'b0;
    logic        ret_dbg = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        link_we;
    logic        link_sel;
    logic [31:0] link_data;
    logic        cause_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctl u0 (.*);

    int vectors = 0;
    int fails   = 0;

    // reference state
    logic [31:0] m_nb = 0, m_db = 0, m_ea = 0, m_ba = 0;
    bit m_remap = 0, m_ie = 0, m_eie = 0, m_bie = 0;
    // expected outputs
    bit e_rv = 0, e_lwe = 0, e_lsel = 0, e_err = 0;
    logic [31:0] e_pc = 0, e_ld = 0;

    function automatic logic [31:0] model_read(input logic [1:0] s);
        case (s)
            2'd0: return m_nb;
            2'd1: return m_db;
            2'd2: return {31'd0, m_remap};
            default: return {29'd0, m_bie, m_eie, m_ie};
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [31:0] e_rd;
        e_rd = model_read(cfg_sel);
        vectors++;
        if (redirect_valid !== e_rv || redirect_pc !== e_pc || link_we !== e_lwe ||
            link_sel !== e_lsel || link_data !== e_ld || cause_err !== e_err ||
            cfg_rdata !== e_rd) begin
            fails++;
            $display("FAIL %s: rv=%0b pc=%h lwe=%0b lsel=%0b ld=%h err=%0b rd=%h | exp rv=%0b pc=%h lwe=%0b lsel=%0b ld=%h err=%0b rd=%h",
                tag, redirect_valid, redirect_pc, link_we, link_sel, link_data, cause_err, cfg_rdata,
                e_rv, e_pc, e_lwe, e_lsel, e_ld, e_err, e_rd);
        end
    endtask

    task automatic step(input string tag, input bit er, input logic [2:0] c,
                        input logic [31:0] pc, input bit re, input bit rb,
                        input bit we, input logic [1:0] s, input logic [31:0] wd);
        bit valid, dbg;
        exc_req = er; exc_cause = c; exc_pc = pc; ret_exc = re; ret_dbg = rb;
        cfg_we = we; cfg_sel = s; cfg_wdata = wd;
        @(posedge clk);
        valid = (c != 3'd7);
        dbg   = valid && (c >= 3'd5);
        e_rv = 0; e_pc = 0; e_lwe = 0; e_lsel = 0; e_ld = 0; e_err = 0;
        if (er && valid) begin
            e_rv = 1; e_lwe = 1; e_lsel = dbg; e_ld = pc;
            e_pc = ((dbg || m_remap) ? m_db : m_nb) + 32'(c) * 32;
            if (dbg) begin m_ba = pc; if (m_ie) m_bie = 1; end
            else     begin m_ea = pc; if (m_ie) m_eie = 1; end
            m_ie = 0;
        end else if (er) begin
            e_err = 1;
        end else if (re) begin
            e_rv = 1; e_pc = m_ea; m_ie = m_eie;
        end else if (rb) begin
            e_rv = 1; e_pc = m_ba; m_ie = m_bie;
        end else if (we && s == 2'd3) begin
            m_ie = wd[0]; m_eie = wd[1]; m_bie = wd[2];
        end
        if (we && s == 2'd0) m_nb = wd & 32'hFFFF_FF00;
        if (we && s == 2'd1) m_db = wd & 32'hFFFF_FF00;
        if (we && s == 2'd2) m_remap = wd[0];
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag, input logic [1:0] s);
        step(tag, 0, 0, 0, 0, 0, 0, s, 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset values on all four registers
        for (int s = 0; s < 4; s++) begin
            cfg_sel = 2'(s);
            #1 compare("R10 reset read");
        end
        @(negedge clk);
        // R10: base writes drop low byte
        step("R10 nbase write", 0, 0, 0, 0, 0, 1, 2'd0, 32'h1000_12FF);
        step("R10 dbase write", 0, 0, 0, 0, 0, 1, 2'd1, 32'h2000_34AB);
        idle("R10 nbase read", 2'd0);
        idle("R10 dbase read", 2'd1);
        // enable global
        step("R10 enable write", 0, 0, 0, 0, 0, 1, 2'd3, 32'h1);
        // R1 R2 R3 R5: every normal cause
        for (int c = 0; c < 5; c++) begin
            step("R2 R3 R5 normal entry", 1, 3'(c), 32'h0000_4000 + 32'(c) * 4, 0, 0, 0, 2'd3, 0);
            idle("R5 enable state", 2'd3);
            step("R8 return exc", 0, 0, 0, 1, 0, 0, 2'd3, 0);
        end
        // R5: entry with enable low leaves saved bit unchanged
        step("R5 clear all", 0, 0, 0, 0, 0, 1, 2'd3, 32'h0);
        step("R5 entry ie low", 1, 3'd3, 32'h5555_0000, 0, 0, 0, 2'd3, 0);
        step("R8 return restores 0", 0, 0, 0, 1, 0, 0, 2'd3, 0);
        // R4 R6: debug causes
        step("R6 enable", 0, 0, 0, 0, 0, 1, 2'd3, 32'h1);
        step("R4 R6 breakpoint", 1, 3'd5, 32'h0000_8800, 0, 0, 0, 2'd3, 0);
        step("R9 return dbg", 0, 0, 0, 0, 1, 0, 2'd3, 0);
        step("R4 R6 watchpoint", 1, 3'd6, 32'h0000_9900, 0, 0, 0, 2'd3, 0);
        step("R9 return dbg 2", 0, 0, 0, 0, 1, 0, 2'd0, 0);
        // R7: remap
        step("R7 remap on", 0, 0, 0, 0, 0, 1, 2'd2, 32'h1);
        step("R7 normal via dbase", 1, 3'd2, 32'h0000_A000, 0, 0, 0, 2'd2, 0);
        step("R7 debug via dbase", 1, 3'd6, 32'h0000_B000, 0, 0, 0, 2'd2, 0);
        step("R7 remap off", 0, 0, 0, 0, 0, 1, 2'd2, 32'h0);
        step("R7 normal via nbase", 1, 3'd4, 32'h0000_C000, 0, 0, 0, 2'd3, 0);
        // R11: undefined cause
        step("R11 set enable", 0, 0, 0, 0, 0, 1, 2'd3, 32'h1);
        step("R11 bad cause", 1, 3'd7, 32'hDEAD_0000, 0, 0, 0, 2'd3, 0);
        step("R11 ea unchanged", 0, 0, 0, 1, 0, 0, 2'd3, 0);
        // R12: precedence
        step("R12 exc beats ret", 1, 3'd1, 32'h0000_D000, 1, 1, 0, 2'd3, 0);
        step("R12 ret_exc beats ret_dbg", 0, 0, 0, 1, 1, 0, 2'd3, 0);
        step("R12 ret beats enable write", 0, 0, 0, 0, 1, 1, 2'd3, 32'h6);
        step("R12 exc blocks enable write", 1, 3'd0, 32'h0000_E000, 0, 0, 1, 2'd3, 32'h7);
        step("R12 base write during exc", 1, 3'd3, 32'h0000_F000, 0, 0, 1, 2'd0, 32'h3000_0000);
        step("R12 new base used", 1, 3'd3, 32'h0000_F100, 0, 0, 0, 2'd0, 0);
        idle("R1 quiet", 2'd1);
        finish_run();
    end
endmodule